// File: doc/BRIEF.md
# Prioritized Transmit Buffer Scheduler

This block tracks a small set of transmit buffers of a CAN FD controller. Each buffer has its own state machine. A command word moves the selected buffers between states. The command carries a buffer-select mask and three action bits: abort, mark-ready and mark-empty. Each action fires only from certain states. A second register holds a 3-bit priority for every buffer. The status word, the priority register and several flags are visible at the ports.

While the controller is enabled and no frame is in flight, the block picks the ready buffer with the highest non-zero priority. It then holds a send request toward the protocol engine until the engine reports completion. Completion moves the buffer to a sent state or a failed state. On success it also steps a frame counter. Every completion produces one-cycle event pulses. Payload storage and the bus protocol live elsewhere.

Top module: `txsched_top`

## Requirements
- R1: After reset every buffer slot reads EMPTY (code 0) and `idle` is 1. In the same state `tx_busy` and `send_req` are 0, `tx_count` is 0 and `not_full` is 1.
- R2: The abort action moves a selected buffer from READY (code 1) to ABORTED (code 4) and leaves every other state alone.
- R3: The mark-ready action moves a selected buffer to READY when it is in EMPTY, SENT (code 2), FAILED (code 3) or ABORTED.
- R4: The mark-empty action moves a selected buffer to EMPTY when it is in SENT, FAILED or ABORTED. A READY buffer is not changed by it.
- R5: When one command carries several action bits, abort is applied first, then mark-ready, then mark-empty. Each step sees the state left by the step before it. The result is visible in `status_word` (buffer i in bits 4i+3..4i, unused bits 0) one cycle after the command.
- R6: A command presented while `enable` is 0 changes no buffer state.
- R7: Buffer i's priority is bits 4i+2..4i of the priority register; `prio_rd` returns these bits and 0 elsewhere. When `enable` is 1 and nothing is in flight, the block launches the READY buffer with the highest priority, using the states after the current command. Priority 0 is never launched, and ties go to the lowest index.
- R8: From the cycle after a launch until completion, `send_req` and `tx_busy` are 1, `idle` is 0 and `send_idx` is held. No other buffer is launched during that time.
- R9: Completion is `send_done` while `send_req` is 1. With `send_ok`=1 the buffer becomes SENT, `tx_count` steps by one and `evt_txdone` and `evt_bufdone` pulse for one cycle. With `send_ok`=0 the buffer becomes FAILED and only `evt_bufdone` pulses.
- R10: An abort aimed at the buffer in flight leaves it READY. The completion decides its final state.
- R11: `not_full` is 1 exactly when at least one buffer is EMPTY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable; gates commands and launches |
| cmd_valid | input | 1 | Command strobe |
| cmd_sel | input | NBUF | Buffer select mask |
| cmd_abort | input | 1 | Abort action |
| cmd_ready | input | 1 | Mark-ready action |
| cmd_empty | input | 1 | Mark-empty action |
| prio_wr | input | 1 | Priority register write strobe |
| prio_word | input | 32 | Priority register write data |
| send_done | input | 1 | Engine completion |
| send_ok | input | 1 | Completion was successful |
| status_word | output | 32 | Packed buffer states |
| prio_rd | output | 32 | Priority register readback |
| send_req | output | 1 | Send request to the engine |
| send_idx | output | IDX_W | Buffer being sent |
| tx_busy | output | 1 | A frame is in flight |
| idle | output | 1 | Nothing in flight |
| not_full | output | 1 | Some buffer is EMPTY |
| tx_count | output | CNT_W | Successful transmission counter |
| evt_txdone | output | 1 | Successful-send event pulse |
| evt_bufdone | output | 1 | Buffer-completion event pulse |

## Verification
The assertions assume the engine raises `send_done` only while `send_req` is 1. A completion with no request is ignored by the design, but the event checks do not cover it. The stimulus keeps to this: the bench's engine model draws a random completion only in cycles where its own model shows a frame in flight. Random commands, masks, priorities and enable toggles are otherwise unconstrained. Directed sequences cover ties, zero priority, chained actions and aborts aimed at the buffer in flight.

// File: rtl/txs_pkg.sv
package txs_pkg;

    localparam int SLOT_W  = 4;
    localparam int MAX_BUF = 8;

    typedef enum logic [SLOT_W-1:0] {
        ST_EMPTY   = 4'd0,
        ST_READY   = 4'd1,
        ST_SENT    = 4'd2,
        ST_FAILED  = 4'd3,
        ST_ABORTED = 4'd4
    } buf_st_e;

endpackage

// File: rtl/txs_slot_next.sv
// Next-state logic of a single transmit buffer.
module txs_slot_next
    import txs_pkg::*;
(
    input  buf_st_e cur,
    input  logic    cmd_en,
    input  logic    sel,
    input  logic    act_abort,
    input  logic    act_ready,
    input  logic    act_empty,
    input  logic    in_flight,
    input  logic    done,
    input  logic    ok,
    output buf_st_e nxt
);

    buf_st_e s;

    always_comb begin
        s = cur;
        if (cmd_en && sel) begin
            // abort first; the frame in flight is protected
            if (act_abort && !in_flight && s == ST_READY) begin
                s = ST_ABORTED;
            end
            // then mark-ready, seeing the result of abort
            if (act_ready && (s == ST_EMPTY || s == ST_SENT ||
                              s == ST_FAILED || s == ST_ABORTED)) begin
                s = ST_READY;
            end
            // then mark-empty, seeing the result of mark-ready
            if (act_empty && (s == ST_SENT || s == ST_FAILED ||
                              s == ST_ABORTED)) begin
                s = ST_EMPTY;
            end
        end
        if (in_flight && done) begin
            s = ok ? ST_SENT : ST_FAILED;
        end
        nxt = s;
    end

endmodule

// File: rtl/txs_pick.sv
// Strict-priority selection among READY buffers.
module txs_pick
    import txs_pkg::*;
#(
    parameter int NBUF   = 4,
    parameter int PRIO_W = 3,
    localparam int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  buf_st_e [NBUF-1:0]              st,
    input  logic    [NBUF-1:0][PRIO_W-1:0]  prio,
    output logic                            found,
    output logic    [IDX_W-1:0]             win
);

    logic [PRIO_W-1:0] best;

    always_comb begin
        found = 1'b0;
        win   = '0;
        best  = '0;
        // a strict compare keeps the lowest index on a tie and skips level 0
        for (int i = 0; i < NBUF; i++) begin
            if (st[i] == ST_READY && prio[i] > best) begin
                best  = prio[i];
                win   = IDX_W'(i);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/txsched_top.sv
module txsched_top
    import txs_pkg::*;
#(
    parameter int NBUF   = 4,
    parameter int PRIO_W = 3,
    parameter int CNT_W  = 16,
    localparam int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              cmd_valid,
    input  logic [NBUF-1:0]   cmd_sel,
    input  logic              cmd_abort,
    input  logic              cmd_ready,
    input  logic              cmd_empty,
    input  logic              prio_wr,
    input  logic [31:0]       prio_word,
    input  logic              send_done,
    input  logic              send_ok,
    output logic [31:0]       status_word,
    output logic [31:0]       prio_rd,
    output logic              send_req,
    output logic [IDX_W-1:0]  send_idx,
    output logic              tx_busy,
    output logic              idle,
    output logic              not_full,
    output logic [CNT_W-1:0]  tx_count,
    output logic              evt_txdone,
    output logic              evt_bufdone
);

    typedef struct packed {
        buf_st_e [NBUF-1:0]             st;
        logic    [NBUF-1:0][PRIO_W-1:0] prio;
        logic                           busy;
        logic    [IDX_W-1:0]            idx;
        logic    [CNT_W-1:0]            cnt;
        logic                           evt_tx;
        logic                           evt_buf;
    } sched_t;

    sched_t q, d;

    buf_st_e [NBUF-1:0] st_nxt;
    logic               cmd_en;
    logic               complete;
    logic               found;
    logic [IDX_W-1:0]   win;

    assign cmd_en   = cmd_valid & enable;
    assign complete = q.busy & send_done;

    for (genvar i = 0; i < NBUF; i++) begin : g_slot
        txs_slot_next u_slot (
            .cur       (q.st[i]),
            .cmd_en    (cmd_en),
            .sel       (cmd_sel[i]),
            .act_abort (cmd_abort),
            .act_ready (cmd_ready),
            .act_empty (cmd_empty),
            .in_flight (q.busy && q.idx == IDX_W'(i)),
            .done      (send_done),
            .ok        (send_ok),
            .nxt       (st_nxt[i])
        );
    end

    txs_pick #(
        .NBUF   (NBUF),
        .PRIO_W (PRIO_W)
    ) u_pick (
        .st    (st_nxt),
        .prio  (q.prio),
        .found (found),
        .win   (win)
    );

    always_comb begin
        d         = q;
        d.st      = st_nxt;
        d.evt_tx  = 1'b0;
        d.evt_buf = 1'b0;
        if (prio_wr) begin
            for (int i = 0; i < NBUF; i++) begin
                d.prio[i] = prio_word[SLOT_W*i +: PRIO_W];
            end
        end
        if (complete) begin
            d.busy    = 1'b0;
            d.evt_buf = 1'b1;
            if (send_ok) begin
                d.evt_tx = 1'b1;
                d.cnt    = q.cnt + 1'b1;
            end
        end else if (enable && !q.busy && found) begin
            d.busy = 1'b1;
            d.idx  = win;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: {NBUF{ST_EMPTY}}, default: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        status_word = '0;
        prio_rd     = '0;
        not_full    = 1'b0;
        for (int i = 0; i < NBUF; i++) begin
            status_word[SLOT_W*i +: SLOT_W] = q.st[i];
            prio_rd[SLOT_W*i +: PRIO_W]     = q.prio[i];
            if (q.st[i] == ST_EMPTY) begin
                not_full = 1'b1;
            end
        end
    end

    assign send_req    = q.busy;
    assign send_idx    = q.idx;
    assign tx_busy     = q.busy;
    assign idle        = ~q.busy;
    assign tx_count    = q.cnt;
    assign evt_txdone  = q.evt_tx;
    assign evt_bufdone = q.evt_buf;

endmodule

// File: rtl/txsched_chk.sv
module txsched_chk #(
    parameter int NBUF  = 4,
    parameter int CNT_W = 16,
    localparam int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             send_req,
    input logic             send_done,
    input logic             send_ok,
    input logic [IDX_W-1:0] send_idx,
    input logic [31:0]      status_word,
    input logic [31:0]      prio_rd,
    input logic [CNT_W-1:0] tx_count,
    input logic             evt_txdone
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        send_req && !send_done |=> send_req && $stable(send_idx)); // R8

    AST_INFLIGHT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        send_req |-> ((status_word >> (4 * int'(send_idx))) & 32'hF) == 32'h1); // R10

    AST_LAUNCH_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(send_req) |-> (($past(prio_rd) >> (4 * int'(send_idx))) & 32'h7) != 32'h0); // R7

    AST_NO_LAUNCH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable && !send_req |=> !send_req); // R7

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(send_req && send_done && send_ok) |=> $stable(tx_count)); // R9

    AST_TXDONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_txdone |=> !evt_txdone); // R9

endmodule

bind txsched_top txsched_chk #(
    .NBUF  (NBUF),
    .CNT_W (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .send_req    (send_req),
    .send_done   (send_done),
    .send_ok     (send_ok),
    .send_idx    (send_idx),
    .status_word (status_word),
    .prio_rd     (prio_rd),
    .tx_count    (tx_count),
    .evt_txdone  (evt_txdone)
);

// File: tb/txsched_top_test.sv
module txsched_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0, cmd_valid = 1'b0, cmd_abort = 1'b0;
    logic        cmd_ready = 1'b0, cmd_empty = 1'b0, prio_wr = 1'b0;
    logic [N-1:0] cmd_sel = '0;
    logic [31:0] prio_word = '0;
    logic        send_done = 1'b0, send_ok = 1'b0;
    logic [31:0] status_word, prio_rd;
    logic        send_req, tx_busy, idle, not_full, evt_txdone, evt_bufdone;
    logic [1:0]  send_idx;
    logic [15:0] tx_count;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // model: 0 EMPTY, 1 READY, 2 SENT, 3 FAILED, 4 ABORTED
    logic [3:0]  mst[N];
    logic [2:0]  mprio[N];
    logic        mbusy, mevt_tx, mevt_buf;
    logic [1:0]  midx;
    logic [15:0] mcnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    txsched_top #(.NBUF(N), .PRIO_W(3), .CNT_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cmd_valid(cmd_valid),
        .cmd_sel(cmd_sel), .cmd_abort(cmd_abort), .cmd_ready(cmd_ready),
        .cmd_empty(cmd_empty), .prio_wr(prio_wr), .prio_word(prio_word),
        .send_done(send_done), .send_ok(send_ok), .status_word(status_word),
        .prio_rd(prio_rd), .send_req(send_req), .send_idx(send_idx),
        .tx_busy(tx_busy), .idle(idle), .not_full(not_full),
        .tx_count(tx_count), .evt_txdone(evt_txdone), .evt_bufdone(evt_bufdone)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status();
        logic [31:0] w = '0;
        for (int i = 0; i < N; i++) w[4*i +: 4] = mst[i];
        return w;
    endfunction

    function automatic logic [31:0] exp_prio();
        logic [31:0] w = '0;
        for (int i = 0; i < N; i++) w[4*i +: 3] = mprio[i];
        return w;
    endfunction

    function automatic logic exp_notfull();
        for (int i = 0; i < N; i++) if (mst[i] == 4'd0) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check_all(string tag);
        chk(tag, "status_word", status_word, exp_status());
        chk(tag, "prio_rd", prio_rd, exp_prio());
        chk(tag, "send_req", 32'(send_req), 32'(mbusy));
        chk(tag, "tx_busy", 32'(tx_busy), 32'(mbusy));
        chk(tag, "idle", 32'(idle), 32'(!mbusy));
        if (mbusy) chk(tag, "send_idx", 32'(send_idx), 32'(midx));
        chk(tag, "tx_count", 32'(tx_count), 32'(mcnt));
        chk("R11", "not_full", 32'(not_full), 32'(exp_notfull()));
        chk(tag, "evt_txdone", 32'(evt_txdone), 32'(mevt_tx));
        chk(tag, "evt_bufdone", 32'(evt_bufdone), 32'(mevt_buf));
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin mst[i] = 4'd0; mprio[i] = 3'd0; end
        mbusy = 0; midx = 0; mcnt = 0; mevt_tx = 0; mevt_buf = 0;
    endtask

    // one clock: model next state from the current inputs, then compare
    task automatic cycle(string tag);
        logic [3:0]  nst[N];
        logic [2:0]  nprio[N];
        logic        nbusy, ntx, nbuf, fnd;
        logic [1:0]  nidx, w;
        logic [2:0]  best;
        logic [15:0] ncnt;
        logic        fl;
        nbusy = mbusy; nidx = midx; ncnt = mcnt; ntx = 0; nbuf = 0;
        for (int i = 0; i < N; i++) begin
            logic [3:0] s = mst[i];
            fl = mbusy && (midx == 2'(i));
            if (enable && cmd_valid && cmd_sel[i]) begin
                if (cmd_abort && !fl && s == 4'd1) s = 4'd4;
                if (cmd_ready && s != 4'd1) s = 4'd1;
                if (cmd_empty && (s == 4'd2 || s == 4'd3 || s == 4'd4)) s = 4'd0;
            end
            if (fl && send_done) s = send_ok ? 4'd2 : 4'd3;
            nst[i] = s;
            nprio[i] = prio_wr ? prio_word[4*i +: 3] : mprio[i];
        end
        fnd = 0; w = 0; best = 0;
        for (int i = 0; i < N; i++)
            if (nst[i] == 4'd1 && mprio[i] > best) begin best = mprio[i]; w = 2'(i); fnd = 1; end
        if (mbusy && send_done) begin
            nbusy = 0; nbuf = 1;
            if (send_ok) begin ntx = 1; ncnt = mcnt + 1; end
        end else if (enable && !mbusy && fnd) begin
            nbusy = 1; nidx = w;
        end
        @(posedge clk);
        for (int i = 0; i < N; i++) begin mst[i] = nst[i]; mprio[i] = nprio[i]; end
        mbusy = nbusy; midx = nidx; mcnt = ncnt; mevt_tx = ntx; mevt_buf = nbuf;
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic cmd(logic [N-1:0] sel, logic ab, logic rd, logic em, string tag);
        cmd_valid = 1; cmd_sel = sel; cmd_abort = ab; cmd_ready = rd; cmd_empty = em;
        cycle(tag);
        cmd_valid = 0; cmd_sel = '0; cmd_abort = 0; cmd_ready = 0; cmd_empty = 0;
    endtask

    task automatic finish_send(logic ok, string tag);
        send_done = 1; send_ok = ok;
        cycle(tag);
        send_done = 0; send_ok = 0;
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R1");
        chk("R1", "idle after reset", 32'(idle), 32'h1);
        chk("R1", "status after reset", status_word, 32'h0);
        rst_n = 1;
        cycle("R1");

        // commands ignored while disabled
        cmd(4'b1111, 0, 1, 0, "R6");
        chk("R6", "status while disabled", status_word, 32'h0);

        enable = 1;
        // all priorities 0: buffers become ready but never launch
        cmd(4'b1111, 0, 1, 0, "R3");
        chk("R3", "all ready", status_word, 32'h1111);
        cycle("R7");
        chk("R7", "prio 0 never sends", 32'(send_req), 32'h0);

        cmd(4'b0001, 1, 0, 0, "R2");
        chk("R2", "buf0 aborted", status_word, 32'h1114);
        cmd(4'b0001, 1, 0, 0, "R2");
        chk("R2", "abort on aborted", status_word, 32'h1114);
        cmd(4'b0011, 0, 0, 1, "R4");
        chk("R4", "empty skips ready", status_word, 32'h1110);
        cmd(4'b0010, 1, 1, 1, "R5");
        chk("R5", "abort+ready+empty", status_word, 32'h1110);
        cmd(4'b0100, 1, 0, 1, "R5");
        chk("R5", "abort+empty", status_word, 32'h1010);
        cmd(4'b0001, 0, 1, 0, "R3");

        // priorities: b0=0 b1=5 b2=5 b3=7
        prio_wr = 1; prio_word = 32'hF7D5_7550; cycle("R7"); prio_wr = 0;
        chk("R7", "prio readback", prio_rd, 32'h0000_7550);
        cmd(4'b0100, 0, 1, 0, "R7");
        cycle("R8");
        chk("R7", "highest first", 32'(send_idx), 32'd3);
        cmd(4'b1000, 1, 0, 0, "R10");
        chk("R10", "in-flight abort ignored", status_word[15:12], 32'h1);
        cycle("R8");
        finish_send(1, "R9");
        chk("R9", "sent", status_word[15:12], 32'h2);
        chk("R9", "count", 32'(tx_count), 32'd1);
        cycle("R7");
        chk("R7", "tie lowest index", 32'(send_idx), 32'd1);
        finish_send(0, "R9");
        chk("R9", "failed", status_word[7:4], 32'h3);
        chk("R9", "count unchanged", 32'(tx_count), 32'd1);
        cycle("R8");
        finish_send(1, "R9");

        // random phase
        void'($urandom(32'd1234));
        for (int k = 0; k < 4000; k++) begin
            enable    = ($urandom % 8) != 0;
            cmd_valid = ($urandom % 3) == 0;
            cmd_sel   = N'($urandom);
            cmd_abort = $urandom % 2;
            cmd_ready = $urandom % 2;
            cmd_empty = $urandom % 2;
            prio_wr   = ($urandom % 10) == 0;
            prio_word = $urandom;
            send_done = mbusy && (($urandom % 3) == 0);
            send_ok   = $urandom % 2;
            cycle("R5");
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule